// File: doc/BRIEF.md
# Correlating Global-History Branch Predictor

This block predicts whether a conditional branch is taken. It uses the recent outcomes of all branches in the program together with the branch address. An M-bit global history register holds the results of the last M resolved branches. Low bits of the branch address pick a table row, and each row holds 2^M saturating counters of N bits. The current history value picks one counter in that row, and the counter's top bit is the prediction. So the same branch can be predicted differently depending on how the branches before it went.

The front end presents a fetch address on the lookup port and gets a taken/not-taken answer in the same cycle. When a branch resolves, the back end presents its address and real outcome on the training port. Training adjusts the counter that the pre-branch history selects, then shifts the outcome into the history. The total storage is ENTRIES × 2^M × N counter bits plus M history bits.

Top module: `corr_branch_pred`

## Requirements
- R1: After reset every counter is zero and the history is zero, so a lookup at any address returns not-taken.
- R2: The table row is address bits [log2(ENTRIES)+1:2]. Address bits [1:0], and all bits above the row field, have no effect on which counter is used.
- R3: On a training cycle the history shifts left by one: the outcome (1 = taken) enters bit 0 and the oldest bit is dropped. Without a training cycle the history holds its value.
- R4: Within a row, the counter index is the history value. A training update uses the history as it was before that branch's outcome is shifted in.
- R5: The lookup output is the most significant bit of the counter chosen by the lookup address row and the current history. It is combinational.
- R6: A taken update increments the selected counter and holds it at 2^N-1 once it gets there.
- R7: A not-taken update decrements the selected counter and holds it at 0 once it gets there.
- R8: When a lookup and a training update occur in the same cycle, the lookup returns the state from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Lookup branch address |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| tr_valid | input | 1 | Training update strobe |
| tr_pc | input | PC_W | Address of the resolved branch |
| tr_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that tr_valid and tr_taken are known (not X) on every clock edge after reset. They also assume that a training address is stable around the edge, because the counter and history checks compare state against the values sampled on the previous edge. The stimulus changes inputs only on falling edges, always drives tr_valid and tr_taken to known values, and picks addresses from a small pool with random upper and low bits. This makes row aliasing and counter saturation occur often. Directed runs add long streaks of the same outcome and lookups made in the same cycle as an update.

// File: rtl/corr_branch_pred.sv
module corr_branch_pred #(
  parameter int M       = 2,
  parameter int N       = 2,
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            tr_valid,
  input  logic [PC_W-1:0] tr_pc,
  input  logic            tr_taken
);
  localparam int RW   = $clog2(ENTRIES);
  localparam int IW   = RW + M;
  localparam int SLOTS = ENTRIES << M;
  localparam logic [N-1:0] CMAX = '1;

  logic [M-1:0] hist;
  logic [N-1:0] ctr [SLOTS];

  wire [IW-1:0] lk_idx = {lk_pc[RW+1:2], hist};
  wire [IW-1:0] tr_idx = {tr_pc[RW+1:2], hist};
  wire [N-1:0]  tr_cur = ctr[tr_idx];

  assign lk_taken = ctr[lk_idx][N-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      for (int i = 0; i < SLOTS; i++) ctr[i] <= '0;
    end else if (tr_valid) begin
      hist <= M'({hist, tr_taken});
      if (tr_taken && tr_cur != CMAX)      ctr[tr_idx] <= tr_cur + 1'b1;
      else if (!tr_taken && tr_cur != '0)  ctr[tr_idx] <= tr_cur - 1'b1;
    end
  end

  p_hist_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid |=> hist == M'({$past(hist), $past(tr_taken)}));

  p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_valid |=> $stable(hist));

  p_ctr_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid && tr_taken |=> ctr[$past(tr_idx)] >= $past(tr_cur));

  p_ctr_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid && !tr_taken |=> ctr[$past(tr_idx)] <= $past(tr_cur));

  p_ctr_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid && tr_taken && tr_cur == CMAX |=> ctr[$past(tr_idx)] == CMAX);

  p_ctr_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid && !tr_taken && tr_cur == '0 |=> ctr[$past(tr_idx)] == '0);
endmodule

// File: tb/corr_branch_pred_tb.sv
module corr_branch_pred_tb_top;
  localparam int CLK_P   = 10;
  localparam int M       = 2;
  localparam int N       = 2;
  localparam int ENTRIES = 16;
  localparam int PC_W    = 32;
  localparam int RW      = $clog2(ENTRIES);

  logic clk = 0, rst_n = 0, tr_valid = 0, tr_taken = 0, lk_taken;
  logic [PC_W-1:0] lk_pc = '0, tr_pc = '0;
  int compared = 0, mismatched = 0;
  int mctr [ENTRIES << M];
  int mhist;

  always #(CLK_P/2) clk = ~clk;

  corr_branch_pred #(.M(M), .N(N), .ENTRIES(ENTRIES), .PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_taken(tr_taken));

  function automatic int slot(input logic [PC_W-1:0] pc);
    return (int'(pc[RW+1:2]) << M) | mhist;
  endfunction

  function automatic logic model_pred(input logic [PC_W-1:0] pc);
    return mctr[slot(pc)] >= (1 << (N-1));
  endfunction

  function automatic void model_train(input logic [PC_W-1:0] pc, input logic t);
    int s = slot(pc);
    if (t && mctr[s] < (1 << N) - 1) mctr[s]++;
    else if (!t && mctr[s] > 0) mctr[s]--;
    mhist = ((mhist << 1) | int'(t)) & ((1 << M) - 1);
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic check(input string req, input logic exp);
    compared++;
    if (lk_taken !== exp) begin
      mismatched++;
      $display("FAIL %s pc=%h got=%b exp=%b", req, lk_pc, lk_taken, exp);
    end
  endtask

  // one cycle: drive at negedge, check pre-update lookup, then advance model
  task automatic step(input string req, input logic [PC_W-1:0] lpc,
                      input logic v, input logic [PC_W-1:0] tpc, input logic t);
    @(negedge clk);
    lk_pc = lpc; tr_valid = v; tr_pc = tpc; tr_taken = t;
    #1;
    check(req, model_pred(lpc));
    if (v) model_train(tpc, t);
  endtask

  function automatic logic [PC_W-1:0] rand_pc();
    logic [PC_W-1:0] p = $urandom;
    p[RW+1:2] = RW'($urandom_range(0, 3));
    return p;
  endfunction

  initial begin
    #(CLK_P * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < (ENTRIES << M); i++) mctr[i] = 0;
    mhist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: every row predicts not-taken after reset
    for (int r = 0; r < ENTRIES; r++) step("R1", PC_W'(r << 2), 0, '0, 0);
    // R6: saturate one row upward; history settles at all ones
    for (int k = 0; k < 8; k++) step("R6", 32'h0000_0010, 1, 32'h0000_0010, 1);
    // R2: aliases with different upper and low bits share the row
    step("R2", 32'hABC0_0013, 0, '0, 0);
    step("R2", 32'h0000_0050, 0, '0, 0);
    // R8: lookup of a row in the same cycle it is trained
    for (int k = 0; k < 4; k++) step("R8", 32'h0000_0010, 1, 32'h0000_0010, 0);
    // R7: drive down to the floor
    for (int k = 0; k < 8; k++) step("R7", 32'h0000_0010, 1, 32'h0000_0010, 0);
    // R3 R4: alternating pattern trains distinct history slots of one row
    for (int k = 0; k < 24; k++) step("R4", 32'h0000_0024, 1, 32'h0000_0024, k[0]);
    for (int k = 0; k < 4; k++) step("R3", 32'h0000_0024, 0, '0, 0);
    // R5: constrained random mix
    for (int k = 0; k < 3000; k++)
      step("R5", rand_pc(), 1'($urandom_range(0, 3) != 0), rand_pc(), 1'($urandom));
    report();
  end
endmodule